// File: doc/BRIEF.md
# Host Data Port Prefetch Engine

This block gives a host a single data window into the memory spaces of a coprocessor. The host programs an address register and a configuration register. After that, each access to the data port either sends one word to the selected memory region or takes one word from a read-ahead queue. The queue is filled in bursts. The host asks for a burst by writing the configuration with the run bit set. When the host pops a word while the burst still has words owed, the engine tops the queue up before it returns the head word.

The host side is a held request with a one-cycle acknowledge. The back end is a plain request/response port. It carries a region code, a 32-bit address made of a 16-bit upper part supplied from outside and the 16-bit address register, and write and read data. Only one back-end request is in flight at a time. The back end ends each request with a one-cycle `be_ack` pulse after any number of cycles. A status word shows whether the queue is full or holds data, and a one-cycle interrupt pulse marks completed writes and completed burst starts.

Top module: `cpx_dport`

## Requirements
- R1: After reset `status` is 0x0100, `irq` and `be_req` are low, and host reads of the address (select 1) and configuration (select 2) registers return 0.
- R2: Configuration bits 14:12 choose the region: 0 data, 1 register space, 5 program, 7 external. A data-port write (select 0) in one of these regions issues one back-end write carrying that code, the address and the data. With any other code the write does nothing: no request, no interrupt, no address step.
- R3: In the register space the back-end address carries only address bits 10:0, and bits 31:11 are zero. In the other regions it is `{be_addr_hi, address}`.
- R4: With configuration bit 1 set, the address register steps by one after each completed back-end access. It wraps from 0xFFFF to 0x0000 and never touches the upper part. With bit 1 clear it holds.
- R5: Writing the configuration with bit 4 set empties the queue and starts a burst whose length comes from bits 3:2: 0 gives 1 word, 1 gives 8, 2 gives 16 and 3 is unbounded. The engine fetches min(length,16) words, then pulses `irq` and acknowledges the host.
- R6: Writing the configuration with bit 4 clear empties the queue and zeroes the remaining count. The next data-port read returns 0 without a back-end request.
- R7: A data-port read while words are still owed first fetches min(free slots, words owed) more words, then returns the oldest queued word. Words come back in fetch order.
- R8: A data-port read with an empty queue and nothing owed returns 0 and issues no back-end request.
- R9: In unbounded mode the owed count never runs out. Every pop of a full queue is followed, on the next read, by one new fetch.
- R10: `status` bit 5 means the queue is full. Bits 6 and 0 both mean the queue is not empty. Bit 8 is always 1. All other bits are 0.
- R11: Every data-port write that reaches the back end gives one `irq` pulse once its `be_ack` arrives.
- R12: `be_req` stays high, with region, address and direction stable, until `be_ack`.
- R13: A burst fetch with an invalid region code stores a 0 word in the queue without a back-end request or an address step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, held until `host_ack` |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | 0 data port, 1 address, 2 configuration, 3 unused |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | One-cycle access completion |
| host_rdata | output | 16 | Read result, valid with `host_ack` |
| irq | output | 1 | One-cycle interrupt pulse |
| status | output | 16 | Queue status word |
| be_addr_hi | input | 16 | Upper address part for non-register regions |
| be_req | output | 1 | Back-end request |
| be_we | output | 1 | Back-end direction, 1 = write |
| be_region | output | 3 | Region code of the request |
| be_addr | output | 32 | Back-end word address |
| be_wdata | output | 16 | Back-end write data |
| be_ack | input | 1 | Back-end completion pulse |
| be_rdata | input | 16 | Back-end read data, valid with `be_ack` |

## Verification
Bursts run with each length code, starting from different base addresses. Read data is checked word by word against an address-derived pattern, so any dropped, repeated or reordered fetch shows up. The unbounded run counts back-end requests after every pop, which separates "refill to free space" from "refill a fixed amount" and from "never refill". The region tests use valid codes, an invalid code, and the register space with a wide address. These separate correct routing from address masking errors and from writes or fetches that leak through an invalid code. Cancel mid-burst and end-of-burst reads show the difference between the zero returned by an empty queue and stale queued data.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam logic [2:0] RGN_DATA = 3'd0;
  localparam logic [2:0] RGN_REGS = 3'd1;
  localparam logic [2:0] RGN_PROG = 3'd5;
  localparam logic [2:0] RGN_EXT  = 3'd7;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CFG  = 2'd2;

  localparam int CFG_INC    = 1;
  localparam int CFG_LEN_LO = 2;
  localparam int CFG_RUN    = 4;
  localparam int CFG_RGN_LO = 12;

  localparam logic [1:0] LEN_ENDLESS = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WWAIT, ST_FETCH, ST_FWAIT, ST_POP, ST_DONE
  } dport_st_e;

  function automatic logic rgn_ok(input logic [2:0] r);
    return (r == RGN_DATA) || (r == RGN_REGS) || (r == RGN_PROG) || (r == RGN_EXT);
  endfunction

  function automatic int burst_words(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 8;
      2'd2:    return 16;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/cpx_fifo.sv
module cpx_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      level <= level + LW'(push) - LW'(pop);
    end
  end

  assign head  = mem[rp];
  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);

  AST_FIFO_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) push |-> !full);  // R7
  AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);  // R8
endmodule

// File: rtl/cpx_addr.sv
module cpx_addr
  import cpx_pkg::*;
#(
  parameter int AW = 16,
  parameter int HW = 16,
  parameter int RW = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [AW-1:0]    load_val,
  input  logic             step,
  input  logic [2:0]       rgn,
  input  logic [HW-1:0]    hi,
  output logic [AW-1:0]    addr_q,
  output logic [AW+HW-1:0] bus_addr
);
  always_ff @(posedge clk) begin
    if (rst)       addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (step) addr_q <= addr_q + 1'b1;
  end

  always_comb begin
    if (rgn == RGN_REGS) bus_addr = (AW+HW)'(addr_q[RW-1:0]);
    else                 bus_addr = {hi, addr_q};
  end

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !load && addr_q == '1) |=> addr_q == '0);  // R4
endmodule

// File: rtl/cpx_dport.sv
module cpx_dport
  import cpx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 16,
  parameter int HW    = 16,
  parameter int DEPTH = 16,
  parameter int RW    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_req,
  input  logic             host_we,
  input  logic [1:0]       host_sel,
  input  logic [DW-1:0]    host_wdata,
  output logic             host_ack,
  output logic [DW-1:0]    host_rdata,
  output logic             irq,
  output logic [15:0]      status,
  input  logic [HW-1:0]    be_addr_hi,
  output logic             be_req,
  output logic             be_we,
  output logic [2:0]       be_region,
  output logic [AW+HW-1:0] be_addr,
  output logic [DW-1:0]    be_wdata,
  input  logic             be_ack,
  input  logic [DW-1:0]    be_rdata
);
  localparam int LW  = $clog2(DEPTH) + 1;
  localparam int CAP = (DEPTH > 16) ? DEPTH : 16;
  localparam int CW  = $clog2(CAP) + 1;

  dport_st_e     state;
  logic [DW-1:0] cfg;
  logic [CW-1:0] rem, fcnt;
  logic          endless, to_pop;

  logic [2:0]       rgn;
  logic             inc, accept, a_load, a_step;
  logic [AW-1:0]    addr_q;
  logic [AW+HW-1:0] bus_addr;
  logic             f_push, f_pop, f_flush, f_full, f_empty;
  logic [DW-1:0]    f_wdata, f_head;
  logic [LW-1:0]    f_level;
  logic [CW-1:0]    free_cnt, refill_cnt, new_len, start_cnt;
  logic             new_endless;

  assign rgn    = cfg[CFG_RGN_LO +: 3];
  assign inc    = cfg[CFG_INC];
  assign accept = host_req && !host_ack && (state == ST_IDLE);
  assign a_load = accept && host_we && (host_sel == SEL_ADDR);
  assign a_step = inc && be_ack && ((state == ST_WWAIT) || (state == ST_FWAIT));

  assign f_flush = accept && host_we && (host_sel == SEL_CFG);
  assign f_push  = ((state == ST_FWAIT) && be_ack) ||
                   ((state == ST_FETCH) && (fcnt != '0) && !rgn_ok(rgn));
  assign f_wdata = (state == ST_FWAIT) ? be_rdata : '0;
  assign f_pop   = (state == ST_POP) && !f_empty;

  assign free_cnt    = CW'(DEPTH) - CW'(f_level);
  assign refill_cnt  = (endless || (rem > free_cnt)) ? free_cnt : rem;
  assign new_endless = (host_wdata[CFG_LEN_LO +: 2] == LEN_ENDLESS);
  assign new_len     = CW'(burst_words(host_wdata[CFG_LEN_LO +: 2]));
  assign start_cnt   = (new_endless || (new_len > CW'(DEPTH))) ? CW'(DEPTH) : new_len;

  cpx_addr #(.AW(AW), .HW(HW), .RW(RW)) u_addr (
    .clk(clk), .rst(rst), .load(a_load), .load_val(host_wdata[AW-1:0]),
    .step(a_step), .rgn(rgn), .hi(be_addr_hi), .addr_q(addr_q), .bus_addr(bus_addr)
  );

  cpx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(f_flush), .push(f_push), .wdata(f_wdata),
    .pop(f_pop), .head(f_head), .level(f_level), .full(f_full), .empty(f_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  cfg <= '0;  rem <= '0;  fcnt <= '0;
      endless <= 1'b0;   to_pop <= 1'b0;
      host_ack <= 1'b0;  host_rdata <= '0;  irq <= 1'b0;  status <= 16'h0100;
      be_req <= 1'b0;    be_we <= 1'b0;  be_region <= '0;  be_addr <= '0;  be_wdata <= '0;
    end else begin
      host_ack <= 1'b0;
      irq      <= 1'b0;
      status   <= 16'h0100 | (f_full ? 16'h0020 : 16'h0000) | (!f_empty ? 16'h0041 : 16'h0000);
      case (state)
        ST_IDLE: if (accept) begin
          if (host_we) begin
            case (host_sel)
              SEL_DATA: if (rgn_ok(rgn)) begin
                be_req <= 1'b1;  be_we <= 1'b1;  be_region <= rgn;
                be_addr <= bus_addr;  be_wdata <= host_wdata;  state <= ST_WWAIT;
              end else host_ack <= 1'b1;
              SEL_CFG: begin
                cfg <= host_wdata;
                if (host_wdata[CFG_RUN]) begin
                  rem <= new_len;  endless <= new_endless;  fcnt <= start_cnt;
                  to_pop <= 1'b0;  state <= ST_FETCH;
                end else begin
                  rem <= '0;  endless <= 1'b0;  host_ack <= 1'b1;
                end
              end
              default: host_ack <= 1'b1;
            endcase
          end else begin
            case (host_sel)
              SEL_DATA: if ((rem != '0) || endless) begin
                fcnt <= refill_cnt;  to_pop <= 1'b1;  state <= ST_FETCH;
              end else state <= ST_POP;
              SEL_ADDR: begin host_rdata <= DW'(addr_q); host_ack <= 1'b1; end
              SEL_CFG:  begin host_rdata <= cfg;         host_ack <= 1'b1; end
              default:  begin host_rdata <= '0;          host_ack <= 1'b1; end
            endcase
          end
        end
        ST_WWAIT: if (be_ack) begin
          be_req <= 1'b0;  irq <= 1'b1;  host_ack <= 1'b1;  state <= ST_IDLE;
        end
        ST_FETCH: begin
          if (fcnt == '0) begin
            state <= to_pop ? ST_POP : ST_DONE;
          end else if (rgn_ok(rgn)) begin
            be_req <= 1'b1;  be_we <= 1'b0;  be_region <= rgn;
            be_addr <= bus_addr;  state <= ST_FWAIT;
          end else begin
            fcnt <= fcnt - 1'b1;
            if (!endless) rem <= rem - 1'b1;
          end
        end
        ST_FWAIT: if (be_ack) begin
          be_req <= 1'b0;  fcnt <= fcnt - 1'b1;
          if (!endless) rem <= rem - 1'b1;
          state <= ST_FETCH;
        end
        ST_POP: begin
          host_rdata <= f_empty ? '0 : f_head;
          host_ack <= 1'b1;  state <= ST_IDLE;
        end
        ST_DONE: begin
          irq <= 1'b1;  host_ack <= 1'b1;  state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    (be_req && !be_ack) |=> (be_req && $stable(be_addr) && $stable(be_region) && $stable(be_we)));  // R12
  AST_REQ_VALID_RGN: assert property (@(posedge clk) disable iff (rst)
    be_req |-> rgn_ok(be_region));  // R2
  AST_REG_SPACE_ADDR: assert property (@(posedge clk) disable iff (rst)
    (be_req && be_region == RGN_REGS) |-> (be_addr[AW+HW-1:RW] == '0));  // R3
  AST_CANCEL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (accept && host_we && host_sel == SEL_CFG && !host_wdata[CFG_RUN]) |=> (f_empty && rem == '0));  // R6
  AST_WRITE_IRQ: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WWAIT && be_ack) |=> irq);  // R11
endmodule

// File: tb/cpx_dport_tb.sv
module cpx_dport_tb;
  localparam logic [15:0] HI = 16'h0003;

  logic        clk = 0, rst = 1;
  logic        host_req = 0, host_we = 0;
  logic [1:0]  host_sel = 0;
  logic [15:0] host_wdata = 0;
  logic        host_ack, irq, be_req, be_we;
  logic [15:0] host_rdata, status, be_wdata;
  logic [2:0]  be_region;
  logic [31:0] be_addr;
  logic        be_ack = 0;
  logic [15:0] be_rdata = 0;

  int checks = 0, fails = 0, nreq = 0, nwr = 0, irqs = 0;
  logic [2:0]  last_rgn;
  logic [31:0] last_addr;
  logic [15:0] last_wd;
  bit done = 0;

  always #10 clk = ~clk;

  cpx_dport u_dut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata), .irq(irq),
    .status(status), .be_addr_hi(HI), .be_req(be_req), .be_we(be_we), .be_region(be_region),
    .be_addr(be_addr), .be_wdata(be_wdata), .be_ack(be_ack), .be_rdata(be_rdata)
  );

  function automatic logic [15:0] mdl(input logic [31:0] a);
    return a[15:0] ^ a[31:16] ^ 16'h5A3C;
  endfunction

  function automatic logic [15:0] cfgw(input logic [2:0] r, input logic [1:0] len,
                                       input logic run, input logic inc);
    return {1'b0, r, 7'b0, run, len, inc, 1'b0};
  endfunction

  // back-end responder with varying latency
  initial begin
    int wait_n = -1;
    forever begin
      @(negedge clk);
      if (be_ack) be_ack = 0;
      else if (be_req) begin
        if (wait_n < 0) wait_n = nreq % 3;
        if (wait_n == 0) begin
          be_ack = 1;  nreq++;  wait_n = -1;
          last_rgn = be_region;  last_addr = be_addr;
          if (be_we) begin nwr++; last_wd = be_wdata; end
          else be_rdata = mdl(be_addr);
        end else wait_n--;
      end
    end
  end

  initial forever begin @(negedge clk); if (irq) irqs++; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] sel, input logic we, input logic [15:0] wd,
                     output logic [15:0] rd);
    int t = 0;
    @(negedge clk);
    host_sel = sel;  host_we = we;  host_wdata = wd;  host_req = 1;
    do begin @(negedge clk); t++; end while (!host_ack && t < 2000);
    if (!host_ack) chk("R12 host handshake", 0, 1);
    rd = host_rdata;  host_req = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] rd;
    chk("R1 status", status, 16'h0100);
    chk("R1 irq", irq, 0);
    chk("R1 be_req", be_req, 0);
    acc(1, 0, 0, rd);  chk("R1 addr reg", rd, 0);
    acc(2, 0, 0, rd);  chk("R1 cfg reg", rd, 0);
  endtask

  task automatic t_regions();
    logic [15:0] rd;
    logic [2:0] codes [4] = '{3'd0, 3'd1, 3'd5, 3'd7};
    for (int i = 0; i < 4; i++) begin
      int w0, i0;
      acc(2, 1, cfgw(codes[i], 0, 0, 0), rd);
      acc(1, 1, 16'h1234, rd);
      w0 = nwr;  i0 = irqs;
      acc(0, 1, 16'hBE00 + 16'(i), rd);
      chk("R2 write issued", nwr - w0, 1);
      chk("R2 region code", last_rgn, codes[i]);
      chk("R2 write data", last_wd, 16'hBE00 + 16'(i));
      chk("R3 address form", last_addr, (codes[i] == 3'd1) ? 32'h0000_0234 : {HI, 16'h1234});
      chk("R11 write irq", irqs - i0, 1);
      acc(1, 0, 0, rd);  chk("R4 no step when clear", rd, 16'h1234);
    end
    begin
      int w0, i0;
      acc(2, 1, cfgw(3'd2, 0, 0, 1), rd);
      w0 = nwr;  i0 = irqs;
      acc(0, 1, 16'hDEAD, rd);
      chk("R2 invalid no write", nwr - w0, 0);
      chk("R2 invalid no irq", irqs - i0, 0);
      acc(1, 0, 0, rd);  chk("R2 invalid no step", rd, 16'h1234);
    end
  endtask

  task automatic t_autoinc();
    logic [15:0] rd;
    acc(2, 1, cfgw(3'd5, 0, 0, 1), rd);
    acc(1, 1, 16'hFFFF, rd);
    acc(0, 1, 16'h0001, rd);
    chk("R4 pre-wrap addr", last_addr, {HI, 16'hFFFF});
    acc(1, 0, 0, rd);  chk("R4 wrap to zero", rd, 16'h0000);
    acc(0, 1, 16'h0002, rd);
    chk("R4 upper part kept", last_addr, {HI, 16'h0000});
  endtask

  task automatic t_burst(input logic [1:0] code, input int n, input logic [15:0] base);
    logic [15:0] rd;
    int r0, i0;
    acc(1, 1, base, rd);
    r0 = nreq;  i0 = irqs;
    acc(2, 1, cfgw(3'd0, code, 1, 1), rd);
    chk("R5 start fetch count", nreq - r0, n);
    chk("R5 start irq", irqs - i0, 1);
    chk("R10 status after start", status, (n == 16) ? 16'h0161 : 16'h0141);
    for (int i = 0; i < n; i++) begin
      acc(0, 0, 0, rd);
      chk("R7 word order", rd, mdl({HI, base + 16'(i)}));
    end
    chk("R10 status drained", status, 16'h0100);
    r0 = nreq;
    acc(0, 0, 0, rd);
    chk("R8 empty read zero", rd, 0);
    chk("R8 no request", nreq - r0, 0);
  endtask

  task automatic t_unbounded();
    logic [15:0] rd;
    int r0;
    acc(1, 1, 16'h0200, rd);
    r0 = nreq;
    acc(2, 1, cfgw(3'd7, 2'd3, 1, 1), rd);
    chk("R5 unbounded first fill", nreq - r0, 16);
    chk("R10 status full", status, 16'h0161);
    acc(0, 0, 0, rd);
    chk("R7 pop from full", rd, mdl({HI, 16'h0200}));
    chk("R7 no refill while full", nreq - r0, 16);
    for (int k = 1; k < 20; k++) begin
      acc(0, 0, 0, rd);
      chk("R9 endless data", rd, mdl({HI, 16'h0200 + 16'(k)}));
    end
    chk("R9 refill one per pop", nreq - r0, 35);
    acc(2, 1, cfgw(3'd7, 2'd3, 0, 1), rd);
    chk("R6 cancel status", status, 16'h0100);
    r0 = nreq;
    acc(0, 0, 0, rd);
    chk("R6 read after cancel", rd, 0);
    chk("R6 no request", nreq - r0, 0);
  endtask

  task automatic t_invalid_fetch();
    logic [15:0] rd;
    int r0;
    acc(1, 1, 16'h0040, rd);
    r0 = nreq;
    acc(2, 1, cfgw(3'd3, 2'd1, 1, 1), rd);
    chk("R13 no request", nreq - r0, 0);
    chk("R13 zeros queued", status, 16'h0141);
    for (int i = 0; i < 8; i++) begin
      acc(0, 0, 0, rd);
      chk("R13 zero word", rd, 0);
    end
    chk("R13 queue drained", status, 16'h0100);
    acc(1, 0, 0, rd);  chk("R13 no step", rd, 16'h0040);
  endtask

  task automatic t_cancel_mid();
    logic [15:0] rd;
    acc(1, 1, 16'h0300, rd);
    acc(2, 1, cfgw(3'd1, 2'd1, 1, 1), rd);
    acc(0, 0, 0, rd);  chk("R3 register space data", rd, mdl(32'h0000_0300));
    acc(0, 0, 0, rd);  chk("R7 second word", rd, mdl(32'h0000_0301));
    acc(2, 1, cfgw(3'd1, 2'd1, 0, 1), rd);
    chk("R6 mid cancel status", status, 16'h0100);
    acc(0, 0, 0, rd);  chk("R6 stale data gone", rd, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk("R12 watchdog", 0, 1);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regions();
    t_autoinc();
    t_burst(2'd0, 1, 16'h0100);
    t_burst(2'd1, 8, 16'h0110);
    t_burst(2'd2, 16, 16'hFFF8);
    t_unbounded();
    t_invalid_fetch();
    t_cancel_mid();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule